// File: doc/BRIEF.md
# Branch Direction Predictor with Saturating Counters

This block guesses whether a conditional branch will be taken. It keeps a small table of 2-bit saturating counters and selects one counter with the low word-address bits of the branch PC. No tags are stored, so two branches whose PCs share those bits share one counter. The block predicts only the direction: branch targets are computed in decode, so the block stores no targets.

The fetch side gives a PC on the lookup port. It gets back a combinational taken/not-taken guess, read from the registered counter state. When a branch resolves, its PC and actual outcome come in on the update port. On the next clock edge the selected counter steps toward that outcome. On the same edge a profiling counter records whether the guess made from the old counter state was wrong. The table holds 4 or 8 slots, set by a parameter.

Top module: `branch_dir_predictor`

## Requirements
- R1: After reset every counter holds 00, so every lookup predicts not taken, and the mispredict count is 0.
- R2: `lkp_taken` is 1 exactly when the counter selected by `lkp_pc` holds 10 or 11. States 00 and 01 give 0.
- R3: A valid update with `upd_taken`=1 moves the selected counter one step up: 00 to 01, 01 to 10, 10 to 11. A counter at 11 stays at 11.
- R4: A valid update with `upd_taken`=0 moves the selected counter one step down: 11 to 10, 10 to 01, 01 to 00. A counter at 00 stays at 00.
- R5: The slot is chosen by PC bits [log2(SLOTS)+1:2]. PC bits [1:0] and all bits above the index are ignored, so with 8 slots 0x1C40 and 0x1C60 use slot 0 and 0x1C5C uses slot 7.
- R6: When `upd_valid` is 0, no counter changes and the mispredict count holds, whatever the other update inputs are.
- R7: On a valid update, `miss_count` rises by one on the next edge when bit 1 of the selected counter before the update differs from `upd_taken`. Otherwise it holds.
- R8: When a lookup and an update select the same slot in the same cycle, the lookup returns the prediction from before the update. The new state appears from the next cycle on.
- R9: `miss_count` saturates at all ones and does not wrap.
- R10: The block works with SLOTS set to 4 or to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_pc | input | PC_W | PC of the branch to predict |
| lkp_taken | output | 1 | Prediction for `lkp_pc`: 1 means taken |
| upd_valid | input | 1 | A resolved branch is present on the update port |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |
| miss_count | output | CNT_W | Saturating count of mispredicted updates |

## Verification
If a counter holds the wrong state, the error reaches `lkp_taken` only when a lookup selects that slot. It shows only when the wrong bit is bit 1, or after later updates carry it across the 01/10 boundary. A wrong step therefore stays hidden until later. `miss_count` shows a wrong pre-update prediction one cycle after the update edge.

The bench checks the lookup in every cycle against a model of the table. It checks `miss_count` after every edge. A wrong counter state therefore shows up within a few cycles of the slot being touched again. Aliased PCs and the 4-slot build make sure that wrong index bits also show at the ports.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_STRONG_NT = 2'b00;
    localparam ctr_t CTR_STRONG_T  = 2'b11;

    // One saturating step toward the resolved outcome
    function automatic ctr_t ctr_step(ctr_t cur, logic taken);
        ctr_t res;
        if (taken) begin
            res = (cur == CTR_STRONG_T) ? cur : ctr_t'(cur + 2'd1);
        end else begin
            res = (cur == CTR_STRONG_NT) ? cur : ctr_t'(cur - 2'd1);
        end
        return res;
    endfunction

endpackage

// File: rtl/bp_index.sv
module bp_index #(
    parameter int SLOTS = 8,
    parameter int PC_W  = 32,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    // word address modulo slot count
    assign idx = pc[IDX_W+1:2];
endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table
    import bp_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic                   wr_taken,
    output logic [SLOTS-1:0][1:0]  slots_q
);
    typedef struct packed {
        logic [SLOTS-1:0][1:0] ctr;
    } tbl_s;

    tbl_s tbl_d, tbl_q;
    logic [SLOTS-1:0][1:0] next_ctr;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_comb begin
            next_ctr[g] = tbl_q.ctr[g];
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                next_ctr[g] = ctr_step(tbl_q.ctr[g], wr_taken);
            end
        end
    end

    always_comb begin
        tbl_d     = tbl_q;
        tbl_d.ctr = next_ctr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign slots_q = tbl_q.ctr;
endmodule

// File: rtl/bp_miss_counter.sv
module bp_miss_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_s;

    cnt_s cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q.cnt != {CNT_W{1'b1}})) begin
            cnt_d.cnt = cnt_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q.cnt;
endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor #(
    parameter int SLOTS = 8,
    parameter int PC_W  = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  lkp_pc,
    output logic             lkp_taken,
    input  logic             upd_valid,
    input  logic [PC_W-1:0]  upd_pc,
    input  logic             upd_taken,
    output logic [CNT_W-1:0] miss_count
);
    localparam int IDX_W = $clog2(SLOTS);

    logic [IDX_W-1:0]      lkp_idx;
    logic [IDX_W-1:0]      upd_idx;
    logic [SLOTS-1:0][1:0] slots_q;
    logic [1:0]            lkp_ctr;
    logic [1:0]            upd_ctr;
    logic                  mispredict;

    bp_index #(.SLOTS(SLOTS), .PC_W(PC_W)) u_lkp_index (
        .pc  (lkp_pc),
        .idx (lkp_idx)
    );

    bp_index #(.SLOTS(SLOTS), .PC_W(PC_W)) u_upd_index (
        .pc  (upd_pc),
        .idx (upd_idx)
    );

    bp_counter_table #(.SLOTS(SLOTS)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken),
        .slots_q  (slots_q)
    );

    // reads come from registered state, so a same-slot update is not yet visible
    always_comb begin
        lkp_ctr    = slots_q[lkp_idx];
        upd_ctr    = slots_q[upd_idx];
        lkp_taken  = lkp_ctr[1];
        mispredict = upd_valid && (upd_ctr[1] != upd_taken);
    end

    bp_miss_counter #(.CNT_W(CNT_W)) u_miss (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (mispredict),
        .count (miss_count)
    );
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
    parameter int SLOTS = 8,
    parameter int CNT_W = 16,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  upd_valid,
    input logic                  upd_taken,
    input logic [IDX_W-1:0]      upd_idx,
    input logic [1:0]            upd_ctr,
    input logic                  mispredict,
    input logic [SLOTS-1:0][1:0] slots_q,
    input logic [CNT_W-1:0]      miss_count
);
    logic                  prev_v_q;
    logic                  prev_t_q;
    logic [IDX_W-1:0]      prev_idx_q;
    logic [1:0]            prev_ctr_q;
    logic [SLOTS-1:0][1:0] prev_slots_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_v_q     <= 1'b0;
            prev_t_q     <= 1'b0;
            prev_idx_q   <= '0;
            prev_ctr_q   <= '0;
            prev_slots_q <= '0;
        end else begin
            prev_v_q     <= upd_valid;
            prev_t_q     <= upd_taken;
            prev_idx_q   <= upd_idx;
            prev_ctr_q   <= upd_ctr;
            prev_slots_q <= slots_q;
        end
    end

    p_taken_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_v_q && prev_t_q) |->
            (slots_q[prev_idx_q] == ((prev_ctr_q == 2'b11) ? 2'b11 : prev_ctr_q + 2'd1)));

    p_nt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_v_q && !prev_t_q) |->
            (slots_q[prev_idx_q] == ((prev_ctr_q == 2'b00) ? 2'b00 : prev_ctr_q - 2'd1)));

    p_idle_table_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> (slots_q == prev_slots_q));

    p_miss_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mispredict && (miss_count != {CNT_W{1'b1}})) |=>
            (miss_count == CNT_W'($past(miss_count) + CNT_W'(1))));

    p_miss_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mispredict |=> $stable(miss_count));

    p_miss_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_count == {CNT_W{1'b1}}) |=> (miss_count == {CNT_W{1'b1}}));
endmodule

bind branch_dir_predictor bp_checker #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_bp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken),
    .upd_idx    (upd_idx),
    .upd_ctr    (upd_ctr),
    .mispredict (mispredict),
    .slots_q    (slots_q),
    .miss_count (miss_count)
);

// File: tb/branch_dir_predictor_bench.sv
module branch_dir_predictor_bench;
    localparam int CW   = 4;
    localparam int MAXC = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] lkp_pc;
    logic        upd_valid;
    logic [31:0] upd_pc;
    logic        upd_taken;
    logic        lkp8, lkp4;
    logic [CW-1:0] miss8, miss4;

    int n_chk = 0;
    int n_err = 0;

    logic [1:0] m8 [8];
    logic [1:0] m4 [4];
    int mm8, mm4;

    always #5 clk = ~clk;

    branch_dir_predictor #(.SLOTS(8), .PC_W(32), .CNT_W(CW)) u_branch_dir_predictor (
        .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .lkp_taken(lkp8),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .miss_count(miss8)
    );

    // R10: 4-slot build driven with the same stimulus
    branch_dir_predictor #(.SLOTS(4), .PC_W(32), .CNT_W(CW)) u_branch_dir_predictor_s4 (
        .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .lkp_taken(lkp4),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .miss_count(miss4)
    );

    function automatic int idx_of(logic [31:0] pc, int slots);
        return int'(pc >> 2) % slots;
    endfunction

    function automatic logic [1:0] nxt(logic [1:0] c, logic t);
        if (t) return (c == 2'b11) ? 2'b11 : c + 2'd1;
        return (c == 2'b00) ? 2'b00 : c - 2'd1;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(logic [31:0] lpc, logic uv, logic [31:0] upc, logic ut, string req);
        int i8, i4;
        @(negedge clk);
        lkp_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
        #1;
        chk(req, int'(lkp8), int'(m8[idx_of(lpc, 8)][1]));
        chk({req, "/R10"}, int'(lkp4), int'(m4[idx_of(lpc, 4)][1]));
        if (uv) begin
            i8 = idx_of(upc, 8);
            i4 = idx_of(upc, 4);
            if (m8[i8][1] != ut && mm8 < MAXC) mm8++;
            if (m4[i4][1] != ut && mm4 < MAXC) mm4++;
            m8[i8] = nxt(m8[i8], ut);
            m4[i4] = nxt(m4[i4], ut);
        end
        @(posedge clk);
        #1;
        chk(uv ? "R7" : "R6", int'(miss8), mm8);
        chk(uv ? "R7/R10" : "R6/R10", int'(miss4), mm4);
    endtask

    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd12345));
        rst_n = 1'b0; lkp_pc = '0; upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0;
        for (int i = 0; i < 8; i++) m8[i] = 2'b00;
        for (int i = 0; i < 4; i++) m4[i] = 2'b00;
        mm8 = 0; mm4 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: all slots not taken after reset, count zero
        for (int i = 0; i < 8; i++) step(32'h1C40 + 32'(i * 4), 1'b0, 32'h1C40, 1'b1, "R1");
        chk("R1", int'(miss8), 0);

        // R3: climb and saturate at 11 on slot 0
        for (int i = 0; i < 4; i++) step(32'h1C40, 1'b1, 32'h1C40, 1'b1, "R3");
        step(32'h1C40, 1'b0, 32'h0, 1'b0, "R3");
        chk("R3", int'(lkp8), 1);

        // R5: aliases and ignored low bits
        step(32'h1C60, 1'b0, 32'h0, 1'b0, "R5");
        step(32'h1C43, 1'b0, 32'h0, 1'b0, "R5");
        step(32'h1C50, 1'b0, 32'h0, 1'b0, "R5");
        step(32'h1C5C, 1'b0, 32'h0, 1'b0, "R5");
        step(32'h1C5C, 1'b1, 32'h1C5F, 1'b1, "R5");
        step(32'h1C5C, 1'b0, 32'h0, 1'b0, "R5");

        // R4: descend and saturate at 00 through alias 0x1C60
        for (int i = 0; i < 5; i++) step(32'h1C40, 1'b1, 32'h1C60, 1'b0, "R4");
        step(32'h1C40, 1'b0, 32'h0, 1'b0, "R4");
        chk("R4", int'(lkp8), 0);

        // R6: update data with valid low changes nothing
        for (int i = 0; i < 4; i++) step(32'h1C40, 1'b0, 32'h1C40, 1'b1, "R6");
        chk("R6", int'(lkp8), 0);

        // R8: same-slot lookup sees the old state
        step(32'h1C44, 1'b1, 32'h1C44, 1'b1, "R8");
        step(32'h1C44, 1'b1, 32'h1C44, 1'b1, "R8");
        step(32'h1C44, 1'b0, 32'h0, 1'b0, "R8");
        chk("R8", int'(lkp8), 1);

        // R2: mixed traffic against the model
        for (int i = 0; i < 300; i++) begin
            step(32'h1C40 + 32'(($urandom % 24) * 4) + 32'($urandom % 4),
                 ($urandom % 4) != 0,
                 32'h1C40 + 32'(($urandom % 24) * 4),
                 1'($urandom % 2), "R2");
        end

        // R9: oscillate 01/10 so every update misses, until saturation
        for (int i = 0; i < 3; i++) step(32'h1C48, 1'b1, 32'h1C48, 1'b0, "R9");
        step(32'h1C48, 1'b1, 32'h1C48, 1'b1, "R9");
        for (int i = 0; i < 20; i++) begin
            step(32'h1C48, 1'b1, 32'h1C48, 1'b1, "R9");
            step(32'h1C48, 1'b1, 32'h1C48, 1'b0, "R9");
        end
        chk("R9", int'(miss8), MAXC);
        chk("R9/R10", int'(miss4), MAXC);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule